// File: doc/BRIEF.md
# Character Attribute Flash and Pixel Output Gate

This block sits at the end of an on-screen display pixel pipeline. For every pixel clock it receives the 16-bit code word of the character under the beam, the glyph bit fetched for that pixel, and a few position flags. From these it forms the red, green, blue and fast-blank outputs. It applies the global display enable, the fast-blank policy and the per-character flashing attribute. The flashing attribute follows one of three duty patterns, which are timed by a frame counter advanced by vertical sync.

Glyph fetching and horizontal position counting are done upstream. The block sees only the resulting pixel bit and the "inside character cell" flag. All four outputs are registered together, so they switch on the same clock edge.

Top module: `osd_attr_gate`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, all four outputs are 0. Reset also returns the flash phase to phase 0, so a character with the flash attribute set is visible under every flash mode.
- R2: When `osd_on` is 0, `red`, `green`, `blue` and `fblank` are all 0 on the following cycle, whatever the other inputs are.
- R3: When `osd_on` is 1 and `strip_en` is 0, the colour outputs are 0 and `fblank` equals `fblank_force`.
- R4: Inside a character cell with the pixel bit set and the character shown, the colour outputs take the foreground enables (code bit 2 drives red, bit 1 drives green, bit 0 drives blue) and `fblank` is 1.
- R5: Inside a character cell, when the pixel is not drawn as foreground and code bit 7 (opaque background) is 1, the colour outputs take code bits 6, 5 and 4 (red, green, blue) and `fblank` is 1.
- R6: When a pixel is not drawn as foreground and has no opaque background, or lies outside a character cell, the colour outputs are 0 and `fblank` equals `fblank_force`.
- R7: With `flash_mode` = 00, the flash attribute (code bit 3) has no effect, and flagged characters are always shown.
- R8: The flash phase (0 to 3) advances after 16 rising edges of `vsync`, then wraps from 3 to 0. A `vsync` that stays high counts once. A rising edge takes effect from the next cycle.
- R9: A character with code bit 3 set is shown in phases 0 and 1 under mode 01, only in phase 0 under mode 10, and in phases 0, 1 and 2 under mode 11. In a hidden phase its foreground pixels fall back to the R5/R6 behaviour.
- R10: Code bits 15 to 8 (character set select and character number) do not affect the outputs.
- R11: The outputs change only on the clock edge after their inputs, all four on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| code_word | input | 16 | Character code word of the current cell |
| pix_bit | input | 1 | Glyph pixel bit for this pixel |
| strip_en | input | 1 | Display enable of the current strip |
| in_char | input | 1 | Pixel lies inside a character cell |
| vsync | input | 1 | Vertical sync; rising edges advance the flash timer |
| osd_on | input | 1 | Global display enable |
| fblank_force | input | 1 | Keep fast-blank high outside drawn pixels |
| flash_mode | input | 2 | Flash duty pattern select |
| red | output | 1 | Red output |
| green | output | 1 | Green output |
| blue | output | 1 | Blue output |
| fblank | output | 1 | Fast-blank output |

## Verification
Two functions can fall in the same cycle: a `vsync` rising edge that moves the flash phase, and the evaluation of a flashing foreground pixel that depends on that phase. The bench provokes this by driving the 16th rising edge of a phase while a flagged character is under the beam. The scoreboard expects that pixel to be judged with the phase from before the edge, and the next pixel with the new phase. A second overlap, a hidden flash phase over a transparent background, is judged by `fblank` following `fblank_force` rather than going high.

// File: rtl/osd_attr_pkg.sv
package osd_attr_pkg;

    localparam int unsigned PHASE_COUNT = 4;
    localparam int unsigned PHASE_W     = 2;

    typedef enum logic [1:0] {
        FLASH_OFF     = 2'b00,
        FLASH_HALF    = 2'b01,
        FLASH_ONE_ON  = 2'b10,
        FLASH_THREE_ON = 2'b11
    } flash_mode_e;

    typedef struct packed {
        logic       set_sel;
        logic [6:0] char_num;
        logic       bg_opaque;
        logic [2:0] bg_rgb;
        logic       flash_attr;
        logic [2:0] fg_rgb;
    } code_word_t;

    typedef struct packed {
        logic [2:0] rgb;
        logic       fblk;
    } pix_out_t;

    localparam pix_out_t PIX_DARK = '{rgb: 3'b000, fblk: 1'b0};

    // Returns 1 when a flagged character is visible in the given phase.
    function automatic logic phase_shows(flash_mode_e mode, logic [PHASE_W-1:0] phase);
        logic vis;
        unique case (mode)
            FLASH_OFF:      vis = 1'b1;
            FLASH_HALF:     vis = (phase < 2'd2);
            FLASH_ONE_ON:   vis = (phase == 2'd0);
            FLASH_THREE_ON: vis = (phase != 2'd3);
            default:        vis = 1'b1;
        endcase
        return vis;
    endfunction

endpackage

// File: rtl/osd_flash_timer.sv
module osd_flash_timer
    import osd_attr_pkg::*;
#(
    parameter int unsigned FRAMES_PER_PHASE = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               vsync,
    output logic [PHASE_W-1:0] phase
);
    localparam int unsigned FRAME_W = (FRAMES_PER_PHASE > 1) ? $clog2(FRAMES_PER_PHASE) : 1;
    localparam logic [FRAME_W-1:0] FRAME_LAST = FRAME_W'(FRAMES_PER_PHASE - 1);

    logic               vsync_q;
    logic               frame_tick;
    logic [FRAME_W-1:0] frame_cnt;

    assign frame_tick = vsync && !vsync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vsync_q   <= 1'b0;
            frame_cnt <= '0;
            phase     <= '0;
        end else begin
            vsync_q <= vsync;
            if (frame_tick) begin
                if (frame_cnt == FRAME_LAST) begin
                    frame_cnt <= '0;
                    phase     <= phase + 1'b1;
                end else begin
                    frame_cnt <= frame_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/osd_pixel_mux.sv
module osd_pixel_mux
    import osd_attr_pkg::*;
(
    input  code_word_t         code,
    input  logic               pix_bit,
    input  logic               strip_en,
    input  logic               in_char,
    input  logic               osd_on,
    input  logic               fblank_force,
    input  flash_mode_e        mode,
    input  logic [PHASE_W-1:0] phase,
    output pix_out_t           pix_out
);
    logic shown;
    logic draw_fg;
    logic unused_code_hi;

    assign unused_code_hi = ^{code.set_sel, code.char_num};
    assign shown   = !code.flash_attr || phase_shows(mode, phase);
    assign draw_fg = pix_bit && shown;

    always_comb begin
        pix_out = '{rgb: 3'b000, fblk: fblank_force};
        if (!osd_on) begin
            pix_out = PIX_DARK;
        end else if (strip_en && in_char) begin
            if (draw_fg) begin
                pix_out = '{rgb: code.fg_rgb, fblk: 1'b1};
            end else if (code.bg_opaque) begin
                pix_out = '{rgb: code.bg_rgb, fblk: 1'b1};
            end
        end
    end
endmodule

// File: rtl/osd_attr_gate.sv
module osd_attr_gate
    import osd_attr_pkg::*;
#(
    parameter int unsigned FRAMES_PER_PHASE = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] code_word,
    input  logic        pix_bit,
    input  logic        strip_en,
    input  logic        in_char,
    input  logic        vsync,
    input  logic        osd_on,
    input  logic        fblank_force,
    input  logic [1:0]  flash_mode,
    output logic        red,
    output logic        green,
    output logic        blue,
    output logic        fblank
);
    logic [PHASE_W-1:0] phase;
    pix_out_t           pix_next;
    pix_out_t           pix_q;

    osd_flash_timer #(
        .FRAMES_PER_PHASE(FRAMES_PER_PHASE)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .vsync (vsync),
        .phase (phase)
    );

    osd_pixel_mux u_mux (
        .code         (code_word_t'(code_word)),
        .pix_bit      (pix_bit),
        .strip_en     (strip_en),
        .in_char      (in_char),
        .osd_on       (osd_on),
        .fblank_force (fblank_force),
        .mode         (flash_mode_e'(flash_mode)),
        .phase        (phase),
        .pix_out      (pix_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q <= PIX_DARK;
        end else begin
            pix_q <= pix_next;
        end
    end

    assign {red, green, blue} = pix_q.rgb;
    assign fblank             = pix_q.fblk;
endmodule

// File: rtl/osd_attr_gate_chk.sv
module osd_attr_gate_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] fg_code,
    input logic       pix_bit,
    input logic       strip_en,
    input logic       in_char,
    input logic       osd_on,
    input logic       fblank_force,
    input logic [1:0] flash_mode,
    input logic       red,
    input logic       green,
    input logic       blue,
    input logic       fblank
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    assert_osd_off_dark_R2: assert property (@(posedge clk) disable iff (rst)
        seen && $past(!osd_on) |-> ({red, green, blue, fblank} == 4'b0000));

    assert_strip_off_R3: assert property (@(posedge clk) disable iff (rst)
        seen && $past(osd_on && !strip_en) |->
            ({red, green, blue} == 3'b000) && (fblank == $past(fblank_force)));

    assert_fg_colour_R4: assert property (@(posedge clk) disable iff (rst)
        seen && $past(osd_on && strip_en && in_char && pix_bit && flash_mode == 2'b00) |->
            ({red, green, blue} == $past(fg_code)) && fblank);

    assert_outside_cell_R6: assert property (@(posedge clk) disable iff (rst)
        seen && $past(osd_on && strip_en && !in_char) |->
            ({red, green, blue} == 3'b000) && (fblank == $past(fblank_force)));

    assert_colour_needs_blank_R11: assert property (@(posedge clk) disable iff (rst)
        !fblank |-> ({red, green, blue} == 3'b000));
endmodule

bind osd_attr_gate osd_attr_gate_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .fg_code      (code_word[2:0]),
    .pix_bit      (pix_bit),
    .strip_en     (strip_en),
    .in_char      (in_char),
    .osd_on       (osd_on),
    .fblank_force (fblank_force),
    .flash_mode   (flash_mode),
    .red          (red),
    .green        (green),
    .blue         (blue),
    .fblank       (fblank)
);

// File: tb/tb_osd_attr_gate.sv
`timescale 1ns/1ps
module tb_osd_attr_gate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] code_word = '0;
    logic        pix_bit = 1'b0;
    logic        strip_en = 1'b0;
    logic        in_char = 1'b0;
    logic        vsync = 1'b0;
    logic        osd_on = 1'b0;
    logic        fblank_force = 1'b0;
    logic [1:0]  flash_mode = 2'b00;
    logic        red, green, blue, fblank;

    always #10 clk = ~clk;

    osd_attr_gate dut (
        .clk(clk), .rst(rst), .code_word(code_word), .pix_bit(pix_bit),
        .strip_en(strip_en), .in_char(in_char), .vsync(vsync), .osd_on(osd_on),
        .fblank_force(fblank_force), .flash_mode(flash_mode),
        .red(red), .green(green), .blue(blue), .fblank(fblank)
    );

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    int         checks = 0;
    int         fails = 0;
    int         frames = 0;
    logic       vs_prev = 1'b0;
    logic [3:0] last_exp = 4'b0000;
    logic [3:0] prev_exp = 4'b0000;

    function automatic logic [3:0] model(logic o, logic f, logic [1:0] m, logic [15:0] c,
                                         logic p, logic s, logic i, int ph);
        logic shown;
        shown = (m == 2'b00) || !c[3] ||
                ((m == 2'b01) ? (ph < 2) : (m == 2'b10) ? (ph == 0) : (ph < 3));
        if (!o) return 4'b0000;
        if (!s || !i) return {3'b000, f};
        if (p && shown) return {c[2:0], 1'b1};
        if (c[7]) return {c[6:4], 1'b1};
        return {3'b000, f};
    endfunction

    task automatic chk(logic [3:0] act, logic [3:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {r,g,b,fb} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(logic o, logic f, logic [1:0] m, logic [15:0] c,
                        logic p, logic s, logic i, logic v, string tag);
        item_t it;
        @(negedge clk);
        osd_on = o; fblank_force = f; flash_mode = m; code_word = c;
        pix_bit = p; strip_en = s; in_char = i; vsync = v;
        it.exp = model(o, f, m, c, p, s, i, (frames / 16) % 4);
        it.tag = tag;
        if (v && !vs_prev) frames++;
        vs_prev = v;
        prev_exp = last_exp;
        last_exp = it.exp;
        sb_q.push_back(it);
    endtask

    // Monitor: compare after every edge that has a pending expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                chk({red, green, blue, fblank}, it.exp, it.tag);
            end
        end
    end

    // Flagged char: fg 101, opaque bg 010, flash bit set.
    localparam logic [15:0] FLASH_CH = 16'h41AD;
    localparam logic [15:0] FLASH_TR = 16'h410D;

    task automatic pulse_frames(int n, string tag);
        for (int k = 0; k < n; k++) begin
            step(1, 0, 2'b10, FLASH_CH, 1, 1, 1, 1, tag);
            step(1, 0, 2'b10, FLASH_CH, 1, 1, 1, 0, tag);
        end
    endtask

    task automatic probe_modes(string tag);
        for (int m = 0; m < 4; m++) step(1, 0, 2'(m), FLASH_CH, 1, 1, 1, 0, tag);
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, inputs asking for colour
        osd_on = 1; strip_en = 1; in_char = 1; pix_bit = 1; code_word = 16'h0007; fblank_force = 1;
        repeat (3) @(posedge clk);
        #2 chk({red, green, blue, fblank}, 4'b0000, "R1 during reset");
        @(negedge clk); rst = 0;
        osd_on = 0; fblank_force = 0;
        @(posedge clk); #2 chk({red, green, blue, fblank}, 4'b0000, "R1 after reset");
        vs_prev = 0;
        // R1: phase 0 after reset, flagged char visible in every mode
        probe_modes("R1 phase0");
        // R2: display off
        step(0, 1, 2'b00, 16'h00F7, 1, 1, 1, 0, "R2 off fg");
        step(0, 1, 2'b01, 16'h00F7, 0, 0, 0, 0, "R2 off outside");
        // R3: strip disabled
        step(1, 1, 2'b00, 16'h00F7, 1, 0, 1, 0, "R3 strip off fbk1");
        step(1, 0, 2'b00, 16'h00F7, 1, 0, 1, 0, "R3 strip off fbk0");
        // R4: foreground colours
        step(1, 0, 2'b00, 16'h0004, 1, 1, 1, 0, "R4 red");
        step(1, 0, 2'b00, 16'h0003, 1, 1, 1, 0, "R4 green blue");
        step(1, 1, 2'b00, 16'h00E1, 1, 1, 1, 0, "R4 blue over bg");
        // R5: opaque background
        step(1, 0, 2'b00, 16'h00C7, 0, 1, 1, 0, "R5 bg red");
        step(1, 0, 2'b00, 16'h0095, 0, 1, 1, 0, "R5 bg blue");
        // R6: transparent / outside
        step(1, 1, 2'b00, 16'h0077, 0, 1, 1, 0, "R6 transparent fbk1");
        step(1, 0, 2'b00, 16'h0077, 0, 1, 1, 0, "R6 transparent fbk0");
        step(1, 1, 2'b00, 16'h00F7, 1, 1, 0, 0, "R6 outside fbk1");
        // R10: high byte ignored
        step(1, 0, 2'b00, 16'hFF05, 1, 1, 1, 0, "R10 hi ff");
        step(1, 0, 2'b00, 16'h0005, 1, 1, 1, 0, "R10 hi 00");
        step(1, 0, 2'b00, 16'h80A2, 0, 1, 1, 0, "R10 set bit");
        // R11: outputs hold until the edge
        step(0, 0, 2'b00, 16'h0000, 0, 0, 0, 0, "R11 new inputs");
        #1 chk({red, green, blue, fblank}, prev_exp, "R11 hold before edge");
        // R8: 15 frames stay in phase 0, 16th edge judged with old phase
        pulse_frames(15, "R8 phase0");
        probe_modes("R9 phase0");
        step(1, 0, 2'b10, FLASH_CH, 1, 1, 1, 1, "R8 edge same cycle");
        step(1, 0, 2'b10, FLASH_CH, 1, 1, 1, 1, "R8 held high");
        // R8: held high many cycles counts once
        for (int k = 0; k < 10; k++) step(1, 0, 2'b10, FLASH_CH, 1, 1, 1, 1, "R8 held high");
        step(1, 0, 2'b10, FLASH_CH, 1, 1, 1, 0, "R8 release");
        probe_modes("R9 phase1");
        step(1, 1, 2'b10, FLASH_TR, 1, 1, 1, 0, "R9 hidden transparent fbk1");
        step(1, 0, 2'b10, FLASH_TR, 1, 1, 1, 0, "R9 hidden transparent fbk0");
        // R7: mode 00 ignores flag in hidden phase
        step(1, 0, 2'b00, FLASH_TR, 1, 1, 1, 0, "R7 mode00 flag ignored");
        pulse_frames(16, "R8 to phase2");
        probe_modes("R9 phase2");
        pulse_frames(16, "R8 to phase3");
        probe_modes("R9 phase3");
        step(1, 0, 2'b00, FLASH_CH, 1, 1, 1, 0, "R7 mode00 phase3");
        pulse_frames(16, "R8 wrap");
        probe_modes("R8 wrapped phase0");
        repeat (3) @(posedge clk);
        #5;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule